// File: doc/BRIEF.md
# Clock and Reset Control Register Bank

This block is a bank of 32-bit control words for a chip's clock and reset controller. It stores the clock gate enables, the source selects, the divider settings, the per-peripheral reset bits, the watchdog reset-routing words and four phase-locked-loop setup words. The clock tree and reset sequencer read these words elsewhere. Software reaches the bank through a simple word-wide bus port. A synchronous cold reset loads every word with a fixed power-on value, so that clock rates can be derived from the bank before software writes anything.

Each loop setup word keeps its own status. It carries a "locked" flag and a sticky "lock lost" flag, and the bank updates both on every write according to the power-down bit in the written data. There is no real loop behind the word, so a loop that is not powered down counts as locked at once. A software-reset word accepts writes but always holds zero. Two read-only time words report seconds and sub-second ticks counted since cold reset.

Top module: `clkctl_regbank`

## Requirements
- R1: While `rst` is high on a clock edge, every word loads its power-on value. These values are: offsets 0x00, 0x28, 0x30, 0x38, 0x3C and 0x40 = 0xFFFFFFFF; 0x04 = 0x004AAAAA; 0x08 = 0x5413F855; 0x2C = 0xAA4F8F9F; 0x20 = 0x00001000; 0x24 = 0x80000000; 0x34 = 0x03000000; 0x44 = 0x00000003; 0x5C = 0x04000003; 0x64 = 0x000000C8; loop words 0x0C = 0x80222101, 0x10 = 0x80202101, 0x54 = 0x80C02105, 0x60 = 0x81228606; all other words = 0.
- R2: An aligned write to any storage word other than the four loop words (0x0C, 0x10, 0x54, 0x60) and the software-reset word (0x14) stores all 32 data bits, and a later read returns them unchanged. The storage words are offsets 0x00 to 0x64.
- R3: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is sampled high, and low otherwise. Read data and `rsp_err` appear in that same cycle. For a write, `rsp_rdata` is zero.
- R4: When a loop word is written with bit 12 (power-down) set, the word stores the written data except that bit 31 (locked) becomes 0 and bit 30 (lock lost) becomes 1.
- R5: When a loop word is written with bit 12 clear, the word stores the written data except for two bits. Bit 31 becomes 1. Bit 30 becomes 0 if the written bit 30 is 1, and otherwise keeps its previous value.
- R6: The software-reset word at 0x14 always reads as zero. A write to it stores zero and does not raise `rsp_err`.
- R7: An access is flagged with `rsp_err` if its address has nonzero bits [1:0] or its word index is 28 or more (offset 0x70 and above). Such an access reads zero and changes no word.
- R8: The time words at 0x68 and 0x6C are read-only. A write to either raises `rsp_err` and leaves both counts unchanged.
- R9: The tick word (0x6C) counts clock cycles since cold reset and wraps from TICK_WRAP-1 to 0. The seconds word (0x68) counts those wraps. A read returns the values held in the cycle the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the 4 KiB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Access out of range, misaligned, or write to a read-only word |

## Verification
Every response is due exactly one clock after its request is sampled. The bench drives each request on a falling edge and samples `rsp_valid`, `rsp_rdata` and `rsp_err` on the next falling edge, after the one register stage has updated. A write takes effect at the edge that samples it, so a read issued on the following falling edge must return the new value, including the status bits the bank rewrote in a loop word. For the time words, the bench keeps its own count of cycles since reset release. It takes the expected tick and seconds from that count at the falling edge where the read is driven, because the design captures the count held before the sampling edge.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int DATA_W      = 32;
    localparam int REG_COUNT   = 28;
    localparam int STORE_COUNT = 26;

    localparam int IDX_PLL0 = 3;
    localparam int IDX_PLL1 = 4;
    localparam int IDX_SWR  = 5;
    localparam int IDX_PLL2 = 21;
    localparam int IDX_GPLL = 24;
    localparam int IDX_SEC  = 26;
    localparam int IDX_TICK = 27;

    localparam int BIT_LOCK = 31;
    localparam int BIT_LOST = 30;
    localparam int BIT_PD   = 12;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_PLL   = 2'd1,
        KIND_WO    = 2'd2,
        KIND_RO    = 2'd3
    } word_kind_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic word_kind_e word_kind(input int idx);
        case (idx)
            IDX_PLL0, IDX_PLL1, IDX_PLL2, IDX_GPLL: return KIND_PLL;
            IDX_SWR:                                return KIND_WO;
            IDX_SEC, IDX_TICK:                      return KIND_RO;
            default:                                return KIND_PLAIN;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            0, 10, 12, 14, 15, 16: return 32'hFFFF_FFFF;
            1:        return 32'h004A_AAAA;
            2:        return 32'h5413_F855;
            11:       return 32'hAA4F_8F9F;
            8:        return 32'h0000_1000;
            9:        return 32'h8000_0000;
            13:       return 32'h0300_0000;
            17:       return 32'h0000_0003;
            23:       return 32'h0400_0003;
            25:       return 32'h0000_00C8;
            IDX_PLL0: return 32'h8022_2101;
            IDX_PLL1: return 32'h8020_2101;
            IDX_PLL2: return 32'h80C0_2105;
            IDX_GPLL: return 32'h8122_8606;
            default:  return '0;
        endcase
    endfunction

    // Status update for a loop setup word on a write.
    function automatic logic [DATA_W-1:0] pll_next(input logic [DATA_W-1:0] old_q,
                                                    input logic [DATA_W-1:0] wr);
        logic [DATA_W-1:0] n;
        n = wr;
        if (wr[BIT_PD]) begin
            n[BIT_LOCK] = 1'b0;
            n[BIT_LOST] = 1'b1;
        end else begin
            n[BIT_LOCK] = 1'b1;
            n[BIT_LOST] = wr[BIT_LOST] ? 1'b0 : old_q[BIT_LOST];
        end
        return n;
    endfunction

endpackage

// File: rtl/clkctl_word.sv
module clkctl_word
    import clkctl_pkg::*;
#(
    parameter word_kind_e        KIND    = KIND_PLAIN,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] q_r;
    logic [DATA_W-1:0] nxt;

    always_comb begin
        case (KIND)
            KIND_PLL: nxt = pll_next(q_r, wdata);
            KIND_WO:  nxt = '0;
            default:  nxt = wdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        q_r <= RST_VAL;
        else if (wr_en) q_r <= nxt;
    end

    assign q = q_r;
endmodule

// File: rtl/clkctl_decode.sv
module clkctl_decode
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output logic [IDX_W-1:0]  idx,
    output logic              hit,
    output logic              err
);
    word_kind_e kind;

    always_comb begin
        idx  = addr[ADDR_W-1:2];
        hit  = (addr[1:0] == 2'b00) && (idx < IDX_W'(REG_COUNT));
        kind = hit ? word_kind(int'(idx)) : KIND_PLAIN;
        err  = !hit || (write && kind == KIND_RO);
    end
endmodule

// File: rtl/clkctl_timebase.sv
module clkctl_timebase
    import clkctl_pkg::*;
#(
    parameter int TICK_WRAP = 25_000_000,
    localparam int TICK_W   = (TICK_WRAP > 1) ? $clog2(TICK_WRAP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] sec_cnt,
    output logic [DATA_W-1:0] tick_cnt
);
    logic [TICK_W-1:0] tick_r;
    logic [DATA_W-1:0] sec_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_r <= '0;
            sec_r  <= '0;
        end else if (tick_r == TICK_W'(TICK_WRAP - 1)) begin
            tick_r <= '0;
            sec_r  <= sec_r + 1'b1;
        end else begin
            tick_r <= tick_r + 1'b1;
        end
    end

    assign sec_cnt  = sec_r;
    assign tick_cnt = DATA_W'(tick_r);
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int TICK_WRAP = 25_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);
    localparam int IDX_W = ADDR_W - 2;

    bus_req_t          req;
    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic              acc_err;
    logic [DATA_W-1:0] word_q [STORE_COUNT];
    logic [DATA_W-1:0] sec_cnt;
    logic [DATA_W-1:0] tick_cnt;
    logic [DATA_W-1:0] rd_mux;
    logic [3:0]        pll_locked;
    logic [3:0]        pll_lost;
    logic [3:0]        pll_pd;

    assign req = '{valid: req_valid, write: req_write, wdata: req_wdata};

    clkctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (req_addr),
        .write (req.write),
        .idx   (idx),
        .hit   (hit),
        .err   (acc_err)
    );

    for (genvar gi = 0; gi < STORE_COUNT; gi++) begin : g_word
        logic wr_en;
        assign wr_en = req.valid && req.write && hit && (idx == IDX_W'(gi));
        clkctl_word #(
            .KIND    (word_kind(gi)),
            .RST_VAL (reset_value(gi))
        ) u_word (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en),
            .wdata (req.wdata),
            .q     (word_q[gi])
        );
    end

    clkctl_timebase #(.TICK_WRAP(TICK_WRAP)) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .sec_cnt  (sec_cnt),
        .tick_cnt (tick_cnt)
    );

    always_comb begin
        rd_mux = '0;
        if (hit) begin
            for (int k = 0; k < STORE_COUNT; k++) begin
                if (idx == IDX_W'(k)) rd_mux = word_q[k];
            end
            if (idx == IDX_W'(IDX_SEC))  rd_mux = sec_cnt;
            if (idx == IDX_W'(IDX_TICK)) rd_mux = tick_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req.valid;
            rsp_rdata <= (req.valid && !req.write) ? rd_mux : '0;
            rsp_err   <= req.valid && acc_err;
        end
    end

    // Loop status bits gathered for the bound checker.
    assign pll_locked = {word_q[IDX_GPLL][BIT_LOCK], word_q[IDX_PLL2][BIT_LOCK],
                         word_q[IDX_PLL1][BIT_LOCK], word_q[IDX_PLL0][BIT_LOCK]};
    assign pll_lost   = {word_q[IDX_GPLL][BIT_LOST], word_q[IDX_PLL2][BIT_LOST],
                         word_q[IDX_PLL1][BIT_LOST], word_q[IDX_PLL0][BIT_LOST]};
    assign pll_pd     = {word_q[IDX_GPLL][BIT_PD], word_q[IDX_PLL2][BIT_PD],
                         word_q[IDX_PLL1][BIT_PD], word_q[IDX_PLL0][BIT_PD]};
endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk
    import clkctl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int TICK_WRAP = 25_000_000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic [3:0]        pll_locked,
    input logic [3:0]        pll_lost,
    input logic [3:0]        pll_pd,
    input logic [DATA_W-1:0] tick_cnt
);
    assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_bad_addr_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ((req_addr[1:0] != 2'b00) ||
                       (req_addr[ADDR_W-1:2] >= (ADDR_W-2)'(REG_COUNT))))
        |=> (rsp_err && rsp_rdata == '0));

    assert_swr_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == ADDR_W'(IDX_SWR * 4))
        |=> (rsp_rdata == '0 && !rsp_err));

    assert_pd_unlocked_R4: assert property (@(posedge clk) disable iff (rst)
        (pll_pd & pll_locked) == 4'b0000);

    assert_lost_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (($past(pll_lost) & ~pll_lost) != 4'b0000) |-> $past(req_valid && req_write));

    assert_tick_bound_R9: assert property (@(posedge clk) disable iff (rst)
        tick_cnt < DATA_W'(TICK_WRAP));
endmodule

bind clkctl_regbank clkctl_regbank_chk #(.ADDR_W(ADDR_W), .TICK_WRAP(TICK_WRAP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .pll_locked (pll_locked),
    .pll_lost   (pll_lost),
    .pll_pd     (pll_pd),
    .tick_cnt   (tick_cnt)
);

// File: tb/test_clkctl_regbank.sv
`timescale 1ns/1ps
module test_clkctl_regbank;
    localparam int ADDR_W = 12;
    localparam int WRAP   = 100;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              rsp_err;

    int          total = 0;
    int          bad   = 0;
    int unsigned cyc   = 0;
    logic [31:0] model [28];

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    clkctl_regbank #(.ADDR_W(ADDR_W), .TICK_WRAP(WRAP)) i_clkctl_regbank (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    function automatic logic [31:0] exp_reset(input int i);
        case (i)
            0, 10, 12, 14, 15, 16: return 32'hFFFFFFFF;
            1: return 32'h004AAAAA;   2: return 32'h5413F855;
            11: return 32'hAA4F8F9F;  8: return 32'h00001000;
            9: return 32'h80000000;   13: return 32'h03000000;
            17: return 32'h00000003;  23: return 32'h04000003;
            25: return 32'h000000C8;  3: return 32'h80222101;
            4: return 32'h80202101;   21: return 32'h80C02105;
            24: return 32'h81228606;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit is_loop(input int i);
        return (i == 3 || i == 4 || i == 21 || i == 24);
    endfunction

    function automatic logic [31:0] exp_loop(input logic [31:0] old_v, input logic [31:0] w);
        logic [31:0] r;
        r = w;
        if (w[12]) begin
            r[31] = 1'b0; r[30] = 1'b1;
        end else begin
            r[31] = 1'b1; r[30] = w[30] ? 1'b0 : old_v[30];
        end
        return r;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // One access: drive on a falling edge, sample on the next falling edge.
    task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          output logic [31:0] rdata, output logic err,
                          output int unsigned cyc_at_drive);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        cyc_at_drive = cyc;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        total++;
        if (rsp_valid !== 1'b1) begin
            bad++;
            $display("FAIL R3 rsp_valid: actual=%0b expected=1", rsp_valid);
        end
        rdata = rsp_rdata; err = rsp_err;
    endtask

    // Access checked against the bench model.
    task automatic model_access(input bit wr, input logic [ADDR_W-1:0] a, input logic [31:0] d, input string req);
        logic [31:0] rd, exp_d;
        logic        e, exp_e;
        int unsigned c;
        int          i;
        bit          aligned;
        i = int'(a[ADDR_W-1:2]);
        aligned = (a[1:0] == 2'b00);
        access(wr, a, d, rd, e, c);
        exp_e = !aligned || i >= 28 || (wr && i >= 26);
        exp_d = 32'h0;
        if (!wr && aligned && i < 28) begin
            if (i == 26)      exp_d = c / WRAP;
            else if (i == 27) exp_d = c % WRAP;
            else              exp_d = model[i];
        end
        if (wr && aligned && i < 26) begin
            if (i == 5)           model[i] = 32'h0;
            else if (is_loop(i))  model[i] = exp_loop(model[i], d);
            else                  model[i] = d;
        end
        check(req, $sformatf("rdata @%03h", a), rd, exp_d);
        check(req, $sformatf("err @%03h", a), {31'b0, e}, {31'b0, exp_e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 28; i++) model[i] = exp_reset(i);
        repeat (3) @(negedge clk);
        check("R3", "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R1: every word after cold reset
        for (int i = 0; i < 28; i++) model_access(1'b0, ADDR_W'(i * 4), 32'h0, "R1");

        // R2: plain words store full data
        model_access(1'b1, 12'h000, 32'h1234_5678, "R2");
        model_access(1'b0, 12'h000, 32'h0, "R2");
        model_access(1'b1, 12'h018, 32'hDEAD_BEEF, "R2");
        model_access(1'b0, 12'h018, 32'h0, "R2");

        // R4 / R5: loop word status handling
        model_access(1'b1, 12'h00C, 32'h0000_1000, "R4");
        model_access(1'b0, 12'h00C, 32'h0, "R4");
        model_access(1'b1, 12'h00C, 32'h0000_2101, "R5");
        model_access(1'b0, 12'h00C, 32'h0, "R5");
        model_access(1'b1, 12'h00C, 32'h4000_2101, "R5");
        model_access(1'b0, 12'h00C, 32'h0, "R5");
        model_access(1'b1, 12'h060, 32'h8000_1FFF, "R4");
        model_access(1'b0, 12'h060, 32'h0, "R4");

        // R6: software-reset word
        model_access(1'b1, 12'h014, 32'hFFFF_FFFF, "R6");
        model_access(1'b0, 12'h014, 32'h0, "R6");

        // R7: out of range and misaligned
        model_access(1'b1, 12'h070, 32'hAAAA_AAAA, "R7");
        model_access(1'b0, 12'h070, 32'h0, "R7");
        model_access(1'b0, 12'hFFC, 32'h0, "R7");
        model_access(1'b1, 12'h002, 32'h5555_5555, "R7");
        model_access(1'b0, 12'h000, 32'h0, "R7");

        // R8: time words are read-only
        model_access(1'b1, 12'h06C, 32'h0000_0050, "R8");
        model_access(1'b0, 12'h06C, 32'h0, "R8");
        model_access(1'b1, 12'h068, 32'h0000_0007, "R8");
        model_access(1'b0, 12'h068, 32'h0, "R8");

        // R9: seconds advance after wraps
        repeat (250) @(negedge clk);
        model_access(1'b0, 12'h068, 32'h0, "R9");
        model_access(1'b0, 12'h06C, 32'h0, "R9");

        // Mixed random traffic
        for (int n = 0; n < 400; n++) begin
            logic [ADDR_W-1:0] a;
            logic [31:0]       d;
            bit                wr;
            a  = ADDR_W'($urandom_range(0, 31) * 4);
            if ($urandom_range(0, 9) == 0) a[1:0] = 2'($urandom_range(1, 3));
            d  = $urandom();
            wr = ($urandom_range(0, 1) == 1);
            model_access(wr, a, d, "R2");
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        // Final sweep of all words
        for (int i = 0; i < 28; i++) model_access(1'b0, ADDR_W'(i * 4), 32'h0, "R2");
        finish_run();
    end
endmodule